// File: doc/BRIEF.md
# Debounced Carrier-Detect Change Queue

This block watches a vector of carrier-detect lines, one bit for each serial port. It removes contact bounce and records every settled change of the whole vector as one event in a small queue for a host to read. The raw lines are asynchronous. Each bit passes through a synchronizer chain, and the synchronized vector is then judged only on cycles where `sample_en` is high. The block keeps two patterns. The accepted pattern is the last one that was recorded. The candidate pattern is the one currently settling.

A candidate must stay identical for a run of sampled cycles before it counts as a change. The length of that run is set by a reload value. A different pattern arriving during the run restarts the count. A settled change is written into a circular queue.

The accepted pattern only moves when the queue has room for the event. If the queue is full, the change stays pending and is offered again on every later matching sample until the host frees a slot. The host sees the oldest queued pattern on `q_data`, sees `q_empty` while nothing is queued, and pulses `pop` to consume one entry. `cd_state` always shows the accepted pattern.

Top module: `cdq_top`

## Requirements
- R1: A sample whose synchronized vector equals the accepted pattern changes nothing: the queue, `cd_state`, the candidate and the remaining count all keep their values, so a pending count resumes where it stopped.
- R2: A sample whose vector differs from both the accepted pattern and the candidate makes the vector the new candidate and reloads the counter to BOUNCE_RELOAD. This restarts any count in progress.
- R3: Each following sample that matches the candidate decrements the counter. The sample that finds the counter already at zero offers the candidate, which is BOUNCE_RELOAD+1 matching samples after the reload. If the queue accepts it, `cd_state` shows the pattern after that clock edge, and never earlier.
- R4: The queue keeps at most 2^QADDR_W-1 entries; it counts as full when advancing the write index would make it equal the read index. An offer made while the queue is full leaves `cd_state` and the queue untouched. The offer repeats on every later matching sample and is accepted on the first one after space appears.
- R5: `pop` with `q_empty` low drops the oldest entry, and `q_data` shows the next one after that edge. `pop` with `q_empty` high is ignored.
- R6: A pop and an accepted offer in the same cycle are both carried out. When one entry was queued before that cycle, only the new pattern remains afterwards, shown on `q_data`.
- R7: After reset `cd_state` is 0, the candidate is 0, the queue is empty and `q_empty` is 1. A first nonzero vector is therefore handled as a change.
- R8: Each raw bit passes through SYNC_STAGES flops before it is compared. A sample taken on the second clock edge after a raw change still uses the previous vector.
- R9: While `sample_en` is low, no raw activity changes `cd_state`, the candidate or the queue.
- R10: Patterns leave the queue in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cd_raw | input | NPORT | Raw carrier-detect lines, asynchronous |
| sample_en | input | 1 | Judge the synchronized vector in this cycle |
| pop | input | 1 | Drop the oldest queued pattern |
| q_data | output | NPORT | Oldest queued pattern (valid while q_empty is 0) |
| q_empty | output | 1 | Queue holds no pattern |
| cd_state | output | NPORT | Accepted carrier-detect pattern |

## Verification
The bench uses a four-port, reload-3, eight-slot configuration and counts samples arithmetically to find the exact sample on which a change must appear. Several input patterns are applied:
- A steady change, which tells a correct run length from one that is off by one.
- A change interrupted by a second pattern, which tells a restarted count from a continued one.
- A change interrupted by a return to the accepted pattern, which tells a preserved count from a reset one.
- A raw change followed at once by a sample, which tells a synchronized vector from an unsynchronized one.
A sweep of every nonzero four-bit pattern through the queue checks ordering. A fill past capacity, followed by a pop and a pop that coincides with a push, separates refused, retried and simultaneous queue operations.

// File: rtl/cdq_pkg.sv
package cdq_pkg;

  // Decision taken by the debounce stage on one sampled cycle
  typedef enum logic [1:0] {
    DB_IDLE,   // no sample, or vector equals the accepted pattern
    DB_LOAD,   // new candidate, counter reloaded
    DB_COUNT,  // candidate confirmed again, counter decremented
    DB_OFFER   // counter exhausted, candidate offered to the queue
  } db_act_e;

endpackage

// File: rtl/cdq_sync.sv
module cdq_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= '0;
          else     chain_q[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= '0;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/cdq_debounce.sv
module cdq_debounce
  import cdq_pkg::*;
#(
  parameter int W      = 7,
  parameter int RELOAD = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sample_en,
  input  logic [W-1:0] pat,
  input  logic         commit,
  output logic         offer,
  output logic [W-1:0] offer_pat,
  output logic [W-1:0] accepted
);

  localparam int CW = $clog2(RELOAD + 1);

  logic [W-1:0]  acc_q;
  logic [W-1:0]  cand_q;
  logic [CW-1:0] cnt_q;
  db_act_e       act;

  always_comb begin
    act = DB_IDLE;
    if (sample_en && (pat != acc_q)) begin
      if (pat != cand_q)     act = DB_LOAD;
      else if (cnt_q != '0)  act = DB_COUNT;
      else                   act = DB_OFFER;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      cand_q <= '0;
      cnt_q  <= CW'(RELOAD);
    end else begin
      unique case (act)
        DB_LOAD: begin
          cand_q <= pat;
          cnt_q  <= CW'(RELOAD);
        end
        DB_COUNT: cnt_q <= cnt_q - 1'b1;
        DB_OFFER: if (commit) acc_q <= cand_q;
        default: ;
      endcase
    end
  end

  assign offer     = (act == DB_OFFER);
  assign offer_pat = cand_q;
  assign accepted  = acc_q;

endmodule

// File: rtl/cdq_fifo.sv
module cdq_fifo #(
  parameter int W  = 7,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic          push_ok,
  output logic [W-1:0]  rd_data,
  output logic          empty,
  output logic [AW-1:0] head_o,
  output logic [AW-1:0] tail_o
);

  localparam int DEPTH = 1 << AW;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] head_q, tail_q, head_n, tail_n;
  logic [W-1:0]  rd_q;
  logic          empty_q;
  logic          pop_ok;

  assign push_ok = push && (AW'(head_q + 1'b1) != tail_q);
  assign pop_ok  = pop && !empty_q;
  assign head_n  = push_ok ? AW'(head_q + 1'b1) : head_q;
  assign tail_n  = pop_ok  ? AW'(tail_q + 1'b1) : tail_q;

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[head_q] <= push_data;
  end

  // registered read of the next oldest entry, with write-first bypass
  always_ff @(posedge clk) begin
    if (rst)                             rd_q <= '0;
    else if (push_ok && head_q == tail_n) rd_q <= push_data;
    else                                 rd_q <= mem[tail_n];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q  <= '0;
      tail_q  <= '0;
      empty_q <= 1'b1;
    end else begin
      head_q  <= head_n;
      tail_q  <= tail_n;
      empty_q <= (head_n == tail_n);
    end
  end

  assign rd_data = rd_q;
  assign empty   = empty_q;
  assign head_o  = head_q;
  assign tail_o  = tail_q;

endmodule

// File: rtl/cdq_top.sv
module cdq_top #(
  parameter int NPORT         = 7,
  parameter int SYNC_STAGES   = 2,
  parameter int BOUNCE_RELOAD = 64,
  parameter int QADDR_W       = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPORT-1:0] cd_raw,
  input  logic             sample_en,
  input  logic             pop,
  output logic [NPORT-1:0] q_data,
  output logic             q_empty,
  output logic [NPORT-1:0] cd_state
);

  logic [NPORT-1:0]   cd_sync;
  logic               offer;
  logic [NPORT-1:0]   offer_pat;
  logic               push_ok;
  logic [QADDR_W-1:0] q_head;
  logic [QADDR_W-1:0] q_tail;

  cdq_sync #(
    .W      (NPORT),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (cd_raw),
    .q   (cd_sync)
  );

  cdq_debounce #(
    .W      (NPORT),
    .RELOAD (BOUNCE_RELOAD)
  ) u_debounce (
    .clk       (clk),
    .rst       (rst),
    .sample_en (sample_en),
    .pat       (cd_sync),
    .commit    (push_ok),
    .offer     (offer),
    .offer_pat (offer_pat),
    .accepted  (cd_state)
  );

  cdq_fifo #(
    .W  (NPORT),
    .AW (QADDR_W)
  ) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (offer),
    .push_data (offer_pat),
    .pop       (pop),
    .push_ok   (push_ok),
    .rd_data   (q_data),
    .empty     (q_empty),
    .head_o    (q_head),
    .tail_o    (q_tail)
  );

endmodule

// File: rtl/cdq_checker.sv
module cdq_checker #(
  parameter int W  = 7,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          sample_en,
  input logic          pop,
  input logic          q_empty,
  input logic [W-1:0]  cd_state,
  input logic [AW-1:0] head,
  input logic [AW-1:0] tail
);

  // R9: accepted pattern only moves on a sampled cycle
  assert_state_needs_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    !sample_en |=> $stable(cd_state));

  // R3: accepted pattern moves only together with a queue write
  assert_state_with_push_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(cd_state) |-> head == AW'($past(head) + 1'b1));

  // R4: the write index never advances onto the read index
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(head) |-> AW'($past(head) + 1'b1) != $past(tail));

  // R5: a pop into an empty queue leaves it empty
  assert_pop_empty_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (q_empty && !sample_en) |=> (q_empty && $stable(tail)));

  // R5: read index moves only on a pop of a non-empty queue
  assert_tail_step_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(tail) |-> ($past(pop) && !$past(q_empty)));

endmodule

bind cdq_top cdq_checker #(
  .W  (NPORT),
  .AW (QADDR_W)
) u_cdq_checker (
  .clk       (clk),
  .rst       (rst),
  .sample_en (sample_en),
  .pop       (pop),
  .q_empty   (q_empty),
  .cd_state  (cd_state),
  .head      (q_head),
  .tail      (q_tail)
);

// File: tb/test_cdq_top.sv
module test_cdq_top;

  localparam int CLK_PERIOD = 10;
  localparam int W   = 4;
  localparam int RLD = 3;
  localparam int AW  = 3;
  localparam int CAP = (1 << AW) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sample_en = 1'b0;
  logic         pop = 1'b0;
  logic [W-1:0] cd_raw = '0;
  logic [W-1:0] q_data;
  logic         q_empty;
  logic [W-1:0] cd_state;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] exp_q[$];

  cdq_top #(
    .NPORT         (W),
    .SYNC_STAGES   (2),
    .BOUNCE_RELOAD (RLD),
    .QADDR_W       (AW)
  ) i_cdq_top (
    .clk       (clk),
    .rst       (rst),
    .cd_raw    (cd_raw),
    .sample_en (sample_en),
    .pop       (pop),
    .q_data    (q_data),
    .q_empty   (q_empty),
    .cd_state  (cd_state)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic strobe();
    @(negedge clk) sample_en = 1'b1;
    @(negedge clk) sample_en = 1'b0;
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) strobe();
  endtask

  task automatic set_raw(input logic [W-1:0] v);
    @(negedge clk) cd_raw = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_pop();
    @(negedge clk) pop = 1'b1;
    @(negedge clk) pop = 1'b0;
  endtask

  task automatic commit(input logic [W-1:0] v);
    set_raw(v);
    strobes(RLD + 2);
    exp_q.push_back(v);
  endtask

  task automatic drain(input string req);
    logic [W-1:0] e;
    while (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      check(req, 32'(q_empty), 32'd0);
      check(req, 32'(q_data), 32'(e));
      do_pop();
    end
    check(req, 32'(q_empty), 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] cur;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7: reset state
    check("R7 empty", 32'(q_empty), 32'd1);
    check("R7 state", 32'(cd_state), 32'd0);

    // R9: raw change without strobes
    set_raw(4'h5);
    repeat (10) @(negedge clk);
    check("R9 state", 32'(cd_state), 32'd0);
    check("R9 empty", 32'(q_empty), 32'd1);

    // R3: commit exactly on the RLD+2nd strobe after the change
    strobes(RLD + 1);
    check("R3 early", 32'(cd_state), 32'd0);
    strobe();
    check("R3 state", 32'(cd_state), 32'h5);
    check("R3 queued", 32'(q_data), 32'h5);

    // R1: return to accepted pattern keeps the count
    set_raw(4'h9);
    strobes(2);
    set_raw(4'h5);
    strobes(4);
    check("R1 state", 32'(cd_state), 32'h5);
    check("R1 queue", 32'(q_data), 32'h5);
    set_raw(4'h9);
    strobes(2);
    check("R1 not yet", 32'(cd_state), 32'h5);
    strobe();
    check("R1 resumed", 32'(cd_state), 32'h9);

    // R2: second pattern restarts the count
    set_raw(4'h3);
    strobes(2);
    set_raw(4'h6);
    strobes(RLD + 1);
    check("R2 restart", 32'(cd_state), 32'h9);
    strobe();
    check("R2 state", 32'(cd_state), 32'h6);

    // R5: pops in order and pop on empty
    check("R5 head0", 32'(q_data), 32'h5);
    do_pop();
    check("R5 head1", 32'(q_data), 32'h9);
    do_pop();
    check("R5 head2", 32'(q_data), 32'h6);
    do_pop();
    check("R5 empty", 32'(q_empty), 32'd1);
    do_pop();
    check("R5 pop empty", 32'(q_empty), 32'd1);
    commit(4'hA);
    drain("R5 after empty pop");

    // R10: sweep every nonzero pattern in batches
    cur = 4'hA;
    for (int v = 1; v < 16; v++) begin
      if (4'(v) != cur) begin
        commit(4'(v));
        cur = 4'(v);
        check("R10 state", 32'(cd_state), 32'(v));
        if (exp_q.size() == 5) drain("R10 order");
      end
    end
    drain("R10 order");

    // R4: fill, refuse, retry
    for (int v = 1; v <= CAP; v++) commit(4'(v));
    check("R4 filled", 32'(q_empty), 32'd0);
    set_raw(4'h8);
    strobes(RLD + 2);
    check("R4 refused", 32'(cd_state), 32'(CAP));
    strobes(2);
    check("R4 still refused", 32'(cd_state), 32'(CAP));
    check("R4 head", 32'(q_data), 32'h1);
    do_pop();
    void'(exp_q.pop_front());
    // R8: raw back to accepted, strobe on the second edge sees stale vector
    @(negedge clk) cd_raw = 4'(CAP);
    @(negedge clk) sample_en = 1'b1;
    @(negedge clk) sample_en = 1'b0;
    check("R8 stale sample", 32'(cd_state), 32'h8);
    exp_q.push_back(4'h8);
    drain("R4 contents");

    // R6: push and pop in one cycle
    commit(4'h2);
    void'(exp_q.pop_front());
    set_raw(4'hC);
    strobes(RLD + 1);
    @(negedge clk) begin sample_en = 1'b1; pop = 1'b1; end
    @(negedge clk) begin sample_en = 1'b0; pop = 1'b0; end
    check("R6 state", 32'(cd_state), 32'hC);
    check("R6 empty", 32'(q_empty), 32'd0);
    check("R6 data", 32'(q_data), 32'hC);
    do_pop();
    check("R6 drained", 32'(q_empty), 32'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule